// File: doc/BRIEF.md
# Configuration Download Sequencer

This block drives a complete configuration load into a target device that listens as an SPI slave. After a start strobe it performs a fixed command sequence. It enables in-system configuration and reads back a one-byte acknowledge, which must be zero. It then switches the target into programming mode, streams the bitstream as fixed-size frames, leaves configuration mode and, after a minimum settling delay, releases the target into user operation. A status-poll engine, which lives outside the block, is asked for a not-busy check before every chip-select window. For the read-back it is asked for a check on the ready bit instead. The poll engine owns its own retry limit and error decoding.

The SPI side is a byte-level port. The block raises `spi_start` with a byte on `spi_tx` and holds chip select for the whole window. An external serializer shifts the byte and answers with `spi_done` and the received byte. Bitstream bytes enter through a valid/ready stream and are taken only while a frame window is open. `done` and `error` are sticky until the next accepted start. `operating` reports a target that is out of programming mode and whose last polled status was zero.

Top module: `cfg_download_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, and `busy`, `done`, `error`, `operating`, `poll_req`, `spi_start` and `bs_ready` are 0. `operating` stays 0 until a poll has returned status 0x00.
- R2: A start whose `byte_count` is not a multiple of FRAME_BYTES (16) sets `error`, leaves `busy` low, and produces no poll request and no chip-select window.
- R3: Every chip-select window is preceded by exactly one poll request. That poll is made with `poll_mask` 0x00, except the poll before the read-back window, which uses 0x02 (ready is status bit 1).
- R4: The first window carries the single byte 0x0B. The second carries 0x01 followed by one dummy byte 0x00, and the byte received during the dummy is the acknowledge. A non-zero acknowledge sets `error` and ends the run with no further window.
- R5: Programming mode is entered with one window carrying 0xAE then 0x01.
- R6: For a byte count of 16*N there follow N windows. Each window is 0xEE followed by the next 16 stream bytes in arrival order.
- R7: `bs_ready` is high only in a cycle where a frame data byte is being issued inside a window. Exactly 16*N stream bytes are consumed per run.
- R8: After the frames, a window with 0x0C is sent. A window with 0x23 follows it, and the two byte issues are at least DELAY_CYC clock cycles apart. `done` then rises with `error` low.
- R9: A poll answered with `poll_fail` sets `error`, returns the block to idle and leaves `spi_cs_n` high, with no further window.
- R10: `operating` is 1 exactly when the programming-mode flag is clear and the last polled status was 0x00. The flag is set by the program-entry window and cleared by the release window, so `operating` is 0 while frames stream and after a failure that follows program entry.
- R11: A start pulse while `busy` is high is ignored, and the running sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken only when idle |
| byte_count | input | CNT_W | Bitstream length in bytes |
| bs_data | input | 8 | Bitstream byte |
| bs_valid | input | 1 | Bitstream byte present |
| bs_ready | output | 1 | Bitstream byte taken this cycle |
| poll_req | output | 1 | Request a status poll; held until answered |
| poll_mask | output | 8 | Status bits the poll must see set (0 means not-busy only) |
| poll_done | input | 1 | Poll finished (one-cycle pulse) |
| poll_fail | input | 1 | Poll ended in violation, SPI error or timeout |
| poll_status | input | 8 | Status byte seen by the poll |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_start | output | 1 | Issue the byte on spi_tx |
| spi_tx | output | 8 | Byte to shift out |
| spi_done | input | 1 | Byte shifted (one-cycle pulse) |
| spi_rx | input | 8 | Byte received during the last shift |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run completed |
| error | output | 1 | Last run or start aborted |
| operating | output | 1 | Target out of programming mode with clean status |

## Verification
A wrong step register or byte index shows at once on `spi_tx`. The bench then records a wrong byte, an extra or missing byte, or a byte in the wrong chip-select window, at the first issue after the fault. A frame counter off by one shows as a frame count and stream consumption different from 16*N by the end of the run, and a poll mask fault shows on the read-back poll. A delay counter that expires early is caught by measuring the cycle distance between the disable and release issues. A lost programming-mode flag shows as `operating` rising while frames are still being streamed, or after a failure that follows program entry.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_POLL,
        PH_ISSUE,
        PH_WAIT,
        PH_DELAY
    } phase_t;

    typedef enum logic [2:0] {
        SP_ENABLE,
        SP_READBACK,
        SP_PGMENTRY,
        SP_FRAME,
        SP_DISABLE,
        SP_RELEASE
    } step_t;

    localparam logic [7:0] OP_ENABLE    = 8'h0B;
    localparam logic [7:0] OP_READDATA  = 8'h01;
    localparam logic [7:0] OP_DUMMY     = 8'h00;
    localparam logic [7:0] OP_PGM_HEAD  = 8'hAE;
    localparam logic [7:0] OP_PGM_ARG   = 8'h01;
    localparam logic [7:0] OP_FRAME     = 8'hEE;
    localparam logic [7:0] OP_DISABLE   = 8'h0C;
    localparam logic [7:0] OP_RELEASE   = 8'h23;
    localparam logic [7:0] MASK_NONE    = 8'h00;
    localparam logic [7:0] MASK_READY   = 8'h02;

    // Command byte for a step; 'first' selects the leading byte of the window.
    function automatic logic [7:0] cmd_byte(step_t s, logic first);
        case (s)
            SP_ENABLE:   return OP_ENABLE;
            SP_READBACK: return first ? OP_READDATA : OP_DUMMY;
            SP_PGMENTRY: return first ? OP_PGM_HEAD : OP_PGM_ARG;
            SP_FRAME:    return OP_FRAME;
            SP_DISABLE:  return OP_DISABLE;
            default:     return OP_RELEASE;
        endcase
    endfunction

    // Index of the final byte inside the window of a step.
    function automatic int unsigned last_index(step_t s, int unsigned frame_bytes);
        case (s)
            SP_READBACK, SP_PGMENTRY: return 1;
            SP_FRAME:                 return frame_bytes;
            default:                  return 0;
        endcase
    endfunction

    function automatic logic [7:0] mask_for(step_t s);
        return (s == SP_READBACK) ? MASK_READY : MASK_NONE;
    endfunction

endpackage

// File: rtl/cfgseq_frame_ctr.sv
module cfgseq_frame_ctr #(
    parameter int CNT_W       = 24,
    parameter int FRAME_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] count,
    output logic             misaligned,
    output logic             none_left,
    output logic             one_left
);
    localparam int FB_LOG = $clog2(FRAME_BYTES);
    localparam int FR_W   = CNT_W - FB_LOG;

    logic [FR_W-1:0] frames;

    assign misaligned = |count[FB_LOG-1:0];
    assign none_left  = (frames == '0);
    assign one_left   = (frames == FR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            frames <= '0;
        end else if (load) begin
            frames <= count[CNT_W-1:FB_LOG];
        end else if (dec && !none_left) begin
            frames <= frames - FR_W'(1);
        end
    end
endmodule

// File: rtl/cfgseq_delay.sv
module cfgseq_delay #(
    parameter int DELAY_CYC = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic expired
);
    localparam int DW = $clog2(DELAY_CYC + 1);

    logic [DW-1:0] remain;

    assign expired = (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (kick) begin
            remain <= DW'(DELAY_CYC);
        end else if (!expired) begin
            remain <= remain - DW'(1);
        end
    end
endmodule

// File: rtl/cfg_download_seq.sv
module cfg_download_seq
    import cfgseq_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int FRAME_BYTES = 16,
    parameter int DELAY_CYC   = 200000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [7:0]       bs_data,
    input  logic             bs_valid,
    output logic             bs_ready,
    output logic             poll_req,
    output logic [7:0]       poll_mask,
    input  logic             poll_done,
    input  logic             poll_fail,
    input  logic [7:0]       poll_status,
    output logic             spi_cs_n,
    output logic             spi_start,
    output logic [7:0]       spi_tx,
    input  logic             spi_done,
    input  logic [7:0]       spi_rx,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             operating
);
    localparam int IDX_W = $clog2(FRAME_BYTES + 1);

    phase_t           ph;
    step_t            st;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_last;
    logic             prog_mode;
    logic [7:0]       last_status;
    logic             done_q;
    logic             error_q;

    logic misaligned, none_left, one_left;
    logic frame_load, frame_dec, dly_kick, dly_expired;
    logic is_data, issue_ok, win_end;

    assign idx_last  = IDX_W'(last_index(st, FRAME_BYTES));
    assign is_data   = (st == SP_FRAME) && (idx != '0);
    assign issue_ok  = (ph == PH_ISSUE) && (!is_data || bs_valid);
    assign win_end   = (ph == PH_WAIT) && spi_done && (idx == idx_last);

    assign spi_start = issue_ok;
    assign bs_ready  = issue_ok && is_data;
    assign spi_tx    = is_data ? bs_data : cmd_byte(st, idx == '0);
    assign spi_cs_n  = !((ph == PH_ISSUE) || (ph == PH_WAIT));
    assign poll_req  = (ph == PH_POLL);
    assign poll_mask = mask_for(st);

    assign busy      = (ph != PH_IDLE);
    assign done      = done_q;
    assign error     = error_q;
    assign operating = !prog_mode && (last_status == 8'h00);

    assign frame_load = (ph == PH_IDLE) && start && !misaligned;
    assign frame_dec  = win_end && (st == SP_FRAME);
    assign dly_kick   = win_end && (st == SP_DISABLE);

    cfgseq_frame_ctr #(
        .CNT_W       (CNT_W),
        .FRAME_BYTES (FRAME_BYTES)
    ) u_frames (
        .clk        (clk),
        .rst        (rst),
        .load       (frame_load),
        .dec        (frame_dec),
        .count      (byte_count),
        .misaligned (misaligned),
        .none_left  (none_left),
        .one_left   (one_left)
    );

    cfgseq_delay #(
        .DELAY_CYC (DELAY_CYC)
    ) u_settle (
        .clk     (clk),
        .rst     (rst),
        .kick    (dly_kick),
        .expired (dly_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph          <= PH_IDLE;
            st          <= SP_ENABLE;
            idx         <= '0;
            prog_mode   <= 1'b0;
            last_status <= 8'hFF;
            done_q      <= 1'b0;
            error_q     <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        done_q  <= 1'b0;
                        error_q <= misaligned;
                        if (!misaligned) begin
                            ph <= PH_POLL;
                            st <= SP_ENABLE;
                        end
                    end
                end
                PH_POLL: begin
                    if (poll_done) begin
                        last_status <= poll_status;
                        idx         <= '0;
                        if (poll_fail) begin
                            error_q <= 1'b1;
                            ph      <= PH_IDLE;
                        end else begin
                            ph <= PH_ISSUE;
                        end
                    end
                end
                PH_ISSUE: begin
                    if (issue_ok) ph <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (spi_done) begin
                        if (idx != idx_last) begin
                            idx <= idx + IDX_W'(1);
                            ph  <= PH_ISSUE;
                        end else begin
                            ph <= PH_POLL;
                            case (st)
                                SP_ENABLE: st <= SP_READBACK;
                                SP_READBACK: begin
                                    if (spi_rx != 8'h00) begin
                                        error_q <= 1'b1;
                                        ph      <= PH_IDLE;
                                    end else begin
                                        st <= SP_PGMENTRY;
                                    end
                                end
                                SP_PGMENTRY: begin
                                    prog_mode <= 1'b1;
                                    st        <= none_left ? SP_DISABLE : SP_FRAME;
                                end
                                SP_FRAME: st <= one_left ? SP_DISABLE : SP_FRAME;
                                SP_DISABLE: ph <= PH_DELAY;
                                default: begin
                                    prog_mode <= 1'b0;
                                    done_q    <= 1'b1;
                                    ph        <= PH_IDLE;
                                end
                            endcase
                        end
                    end
                end
                PH_DELAY: begin
                    if (dly_expired) begin
                        st <= SP_RELEASE;
                        ph <= PH_POLL;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_download_seq_chk.sv
module cfg_download_seq_chk #(
    parameter int DELAY_CYC = 200000
) (
    input logic       clk,
    input logic       rst,
    input logic       bs_ready,
    input logic       poll_req,
    input logic       spi_cs_n,
    input logic       spi_start,
    input logic [7:0] spi_tx,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       operating
);
    logic        dis_seen;
    logic [31:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_seen <= 1'b0;
            gap      <= '0;
        end else if (spi_start && !bs_ready && spi_tx == 8'h0C) begin
            dis_seen <= 1'b1;
            gap      <= '0;
        end else if (dis_seen && gap != 32'hFFFF_FFFF) begin
            gap <= gap + 32'd1;
        end
    end

    assert_poll_outside_window_R3: assert property (@(posedge clk) disable iff (rst)
        poll_req |-> spi_cs_n);

    assert_stream_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        bs_ready |-> (!spi_cs_n && spi_start));

    assert_settle_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (spi_start && !bs_ready && spi_tx == 8'h23) |-> (dis_seen && gap >= 32'(DELAY_CYC)));

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> (spi_cs_n && !busy));

    assert_not_operating_streaming_R10: assert property (@(posedge clk) disable iff (rst)
        bs_ready |-> !operating);

    assert_clean_finish_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!error && spi_cs_n && !busy));
endmodule

bind cfg_download_seq cfg_download_seq_chk #(.DELAY_CYC(DELAY_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bs_ready  (bs_ready),
    .poll_req  (poll_req),
    .spi_cs_n  (spi_cs_n),
    .spi_start (spi_start),
    .spi_tx    (spi_tx),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .operating (operating)
);

// File: tb/cfg_download_seq_tb.sv
`timescale 1ns/1ps
module cfg_download_seq_tb;
    localparam int CNT_W = 16;
    localparam int FB    = 16;
    localparam int DLY   = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [7:0]       bs_data = '0;
    logic             bs_valid = 1'b0;
    logic             bs_ready;
    logic             poll_req;
    logic [7:0]       poll_mask;
    logic             poll_done = 1'b0;
    logic             poll_fail = 1'b0;
    logic [7:0]       poll_status = '0;
    logic             spi_cs_n;
    logic             spi_start;
    logic [7:0]       spi_tx;
    logic             spi_done = 1'b0;
    logic [7:0]       spi_rx = '0;
    logic             busy, done, error, operating;

    always #2.5 clk = ~clk;

    cfg_download_seq #(.CNT_W(CNT_W), .FRAME_BYTES(FB), .DELAY_CYC(DLY)) u_dut (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
        .bs_data(bs_data), .bs_valid(bs_valid), .bs_ready(bs_ready),
        .poll_req(poll_req), .poll_mask(poll_mask), .poll_done(poll_done),
        .poll_fail(poll_fail), .poll_status(poll_status),
        .spi_cs_n(spi_cs_n), .spi_start(spi_start), .spi_tx(spi_tx),
        .spi_done(spi_done), .spi_rx(spi_rx),
        .busy(busy), .done(done), .error(error), .operating(operating));

    int tests = 0, fails = 0;
    logic [7:0] tx_log [0:255];
    int  tx_win [0:255];
    int  tx_cyc [0:255];
    logic [7:0] mask_log [0:63];
    int  n_tx, n_win, n_poll, bs_ptr, cyc;
    int  scnt, pcnt, poll_idx, fail_at, stall_mode;
    logic [7:0] ack_byte;
    logic prev_cs;
    logic op_while_stream;
    logic finished = 1'b0;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Target models: serializer, poll engine, stream source, monitors.
    initial begin
        n_tx = 0; n_win = 0; n_poll = 0; bs_ptr = 0; cyc = 0;
        scnt = 0; pcnt = 0; poll_idx = 0; fail_at = -1; stall_mode = 0;
        ack_byte = 8'h00; prev_cs = 1'b1; op_while_stream = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            cyc++;
            spi_done = 1'b0; poll_done = 1'b0; poll_fail = 1'b0;
            if (scnt > 0) begin
                scnt--;
                if (scnt == 0) begin spi_done = 1'b1; spi_rx = ack_byte; end
            end
            if (pcnt > 0) begin
                pcnt--;
                if (pcnt == 0) begin
                    poll_done   = 1'b1;
                    poll_fail   = (poll_idx == fail_at);
                    poll_status = (poll_idx == fail_at) ? 8'h04 : 8'h00;
                end
            end
            bs_valid = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            bs_data  = pat(bs_ptr);
            #1;
            if (!spi_cs_n && prev_cs) n_win++;
            prev_cs = spi_cs_n;
            if (bs_ready && operating) op_while_stream = 1'b1;
            if (spi_start) begin
                if (n_tx < 256) begin
                    tx_log[n_tx] = spi_tx; tx_win[n_tx] = n_win; tx_cyc[n_tx] = cyc;
                end
                n_tx++;
                if (bs_ready) bs_ptr++;
                scnt = 2;
            end
            if (poll_req && pcnt == 0 && !poll_done) begin
                if (n_poll < 64) mask_log[n_poll] = poll_mask;
                poll_idx = n_poll;
                n_poll++;
                pcnt = 3;
            end
        end
    end

    task automatic clear_logs();
        n_tx = 0; n_win = 0; n_poll = 0; bs_ptr = 0; op_while_stream = 1'b0;
    endtask

    task automatic launch(input int count, input int mid_start);
        @(negedge clk);
        clear_logs();
        byte_count = CNT_W'(count);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6000 && busy; i++) begin
            @(negedge clk);
            if (i == 40 && mid_start != 0) begin
                byte_count = CNT_W'(48);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        chk(!busy, "R8 run ends", int'(busy), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic full_run(input int nfr, input int stall, input int mid);
        logic [7:0] exp_b [0:255];
        int exp_w [0:255];
        int ne, w, bad_b, bad_w, bad_m;
        stall_mode = stall; fail_at = -1; ack_byte = 8'h00;
        ne = 0;
        exp_b[ne] = 8'h0B; exp_w[ne] = 1; ne++;
        exp_b[ne] = 8'h01; exp_w[ne] = 2; ne++;
        exp_b[ne] = 8'h00; exp_w[ne] = 2; ne++;
        exp_b[ne] = 8'hAE; exp_w[ne] = 3; ne++;
        exp_b[ne] = 8'h01; exp_w[ne] = 3; ne++;
        for (int f = 0; f < nfr; f++) begin
            w = 4 + f;
            exp_b[ne] = 8'hEE; exp_w[ne] = w; ne++;
            for (int j = 0; j < FB; j++) begin
                exp_b[ne] = pat(f * FB + j); exp_w[ne] = w; ne++;
            end
        end
        exp_b[ne] = 8'h0C; exp_w[ne] = 4 + nfr; ne++;
        exp_b[ne] = 8'h23; exp_w[ne] = 5 + nfr; ne++;
        launch(nfr * FB, mid);
        chk(done == 1'b1 && error == 1'b0, "R8 done without error", {30'd0, done, error}, 2);
        chk(n_tx == ne, "R6 byte count", n_tx, ne);
        bad_b = 0; bad_w = 0;
        for (int k = 0; k < ne && k < n_tx; k++) begin
            if (tx_log[k] != exp_b[k]) bad_b++;
            if (tx_win[k] != exp_w[k]) bad_w++;
        end
        chk(bad_b == 0, (mid != 0) ? "R11 bytes unchanged" : "R4 R5 R6 byte order", bad_b, 0);
        chk(bad_w == 0, "R5 R6 window grouping", bad_w, 0);
        chk(n_win == 5 + nfr, "R6 window count", n_win, 5 + nfr);
        chk(n_poll == 5 + nfr, "R3 poll count", n_poll, 5 + nfr);
        bad_m = 0;
        for (int k = 0; k < n_poll && k < 64; k++)
            if (mask_log[k] != ((k == 1) ? 8'h02 : 8'h00)) bad_m++;
        chk(bad_m == 0, "R3 poll masks", bad_m, 0);
        chk(bs_ptr == nfr * FB, "R7 stream consumed", bs_ptr, nfr * FB);
        if (n_tx == ne)
            chk(tx_cyc[ne-1] - tx_cyc[ne-2] >= DLY, "R8 settle gap",
                tx_cyc[ne-1] - tx_cyc[ne-2], DLY);
        chk(operating == 1'b1, "R10 operating after release", int'(operating), 1);
        chk(!op_while_stream, "R10 not operating while streaming", int'(op_while_stream), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n && !busy && !done && !error && !operating && !poll_req && !spi_start && !bs_ready,
            "R1 reset outputs", {21'd0, spi_cs_n, busy, done, error, operating, poll_req, spi_start, bs_ready, 3'd0}, 1024);

        // Sweep frame counts with and without stream stalls (R4 R5 R6 R7 R8 R3 R10)
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 5; n++)
                full_run(n, s, 0);

        // R2 misaligned length
        stall_mode = 0; fail_at = -1;
        launch(20, 0);
        chk(error == 1'b1 && done == 1'b0, "R2 misaligned error", int'(error), 1);
        chk(n_poll == 0 && n_win == 0, "R2 no activity", n_poll + n_win, 0);

        // R4 non-zero acknowledge aborts
        ack_byte = 8'h5A;
        launch(32, 0);
        ack_byte = 8'h00;
        chk(error == 1'b1 && done == 1'b0, "R4 ack abort error", int'(error), 1);
        chk(n_win == 2 && n_tx == 3, "R4 no window after ack", n_tx, 3);
        chk(spi_cs_n == 1'b1, "R4 cs released", int'(spi_cs_n), 1);

        // R9 poll failure before first frame, after program entry
        fail_at = 3;
        launch(32, 0);
        fail_at = -1;
        chk(error == 1'b1 && done == 1'b0, "R9 poll fail error", int'(error), 1);
        chk(n_win == 3 && n_tx == 5, "R9 no window after fail", n_tx, 5);
        chk(spi_cs_n == 1'b1 && busy == 1'b0, "R9 idle with cs high", int'(spi_cs_n), 1);
        chk(operating == 1'b0, "R10 flag held after failed stream", int'(operating), 0);

        // R9 poll failure on the very first poll
        fail_at = 0;
        launch(16, 0);
        fail_at = -1;
        chk(error == 1'b1 && n_win == 0, "R9 first poll fail", n_win, 0);

        // R11 start while busy ignored, with recovery after errors
        full_run(2, 1, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule